// File: doc/BRIEF.md
# Divider Configuration Port with Serial and Parallel Load

This block holds the configuration words of a clock synthesizer: a 9-bit feedback divide value, a 2-bit post-divide select and a 3-bit test-mode select. Two paths can write it. A parallel path takes the divide values straight from pins under a parallel strobe. A three-wire serial path (shift clock, data line, load strobe) fills a 14-bit shift register and then moves the whole frame into the configuration latches. All external control lines are sampled on the system clock through a synchronizer, and their edges are found by comparing successive samples.

A three-state controller decides which source feeds the latches. ST_PAR is entered whenever the synchronized parallel strobe is low; from any state the transition "par_low" leads there. In ST_PAR the latches follow the pins and the test field is held at zero. The transition "par_high" leads from ST_PAR to ST_IDLE, where nothing changes. From ST_IDLE, "ser_high" (serial strobe high) enters ST_SER, where the latches follow the shift register. "ser_low" returns to ST_IDLE, and that freezes the captured frame. Because every transition into ST_PAR is taken first, the parallel path always wins.

Top module: `cfgport_top`

## Requirements
- R1: While reset is asserted, the three latched fields and the serial output read zero. After reset is released with the parallel strobe high and no serial activity, they stay zero.
- R2: The shift register moves once for each rising edge of the serial clock, no matter how long the clock stays high. The new bit enters at the top, and `ser_out` shows the bit at the bottom. After 14 bits, `ser_out` carries the first bit sent, and each later edge brings up the next one.
- R3: A serial frame is sent test bits first, then post-divide bits, then feedback bits, each field MSB first (T2 T1 T0 N1 N0 M8 … M0). After the load strobe is pulsed, `test_sel`, `post_div` and `fb_div` equal the fields sent.
- R4: While the serial load strobe is high (and the parallel strobe is high), the latches follow the shift register, so bits shifted during the strobe appear on the outputs.
- R5: The falling edge of the serial load strobe captures the frame. Later shifting without a strobe does not change the outputs.
- R6: While the parallel strobe is low, `fb_div` and `post_div` follow the parallel pins and `test_sel` reads 000.
- R7: The rising edge of the parallel strobe captures the pins. Later pin changes do not change the outputs.
- R8: The parallel path has priority. A serial strobe while the parallel strobe is low has no effect on any output. Serial loads work again once the parallel strobe is high.
- R9: The test field can only be set serially. A parallel load clears a nonzero test field to 000, and it stays 000 after the parallel strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (sampled) |
| ser_dat | input | 1 | Serial data line |
| ser_ld | input | 1 | Serial load strobe, latches transparent while high |
| par_ld | input | 1 | Parallel load strobe, latches transparent while low |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel post-divide select |
| test_sel | output | 3 | Latched test-mode select |
| post_div | output | 2 | Latched post-divide select |
| fb_div | output | 9 | Latched feedback divide value |
| ser_out | output | 1 | Bottom bit of the shift register |

## Verification
The bench checks where each field lands in the frame. A design that reversed a field, or took the fields from the wrong end of the register, would load M, N or T scrambled, and `ser_out` after a full frame would not carry the first bit. It holds the serial clock high for several cycles, which exposes a level-triggered shifter that moves more than once per pulse. It holds each strobe open while the inputs change and then changes them again after the strobe closes. A design that captured on the wrong edge, or kept the latches open, would then show stale or moving values. Finally it raises the serial strobe while the parallel strobe is low and loads a nonzero test field before a parallel load. Wrong priority would leak the shift register onto the outputs, and a wrong forcing rule would leave T nonzero.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int T_W  = 3;
    localparam int N_W  = 2;
    localparam int M_W  = 9;
    localparam int SR_W = T_W + N_W + M_W;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_PAR  = 3'b001,
        ST_IDLE = 3'b010,
        ST_SER  = 3'b100
    } ld_state_e;

endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgport_shift.sv
module cfgport_shift
    import cfgport_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_s,
    input  logic            sdat_s,
    output logic            sclk_rise,
    output logic [SR_W-1:0] sr_q,
    output cfg_t            sr_cfg
);
    logic sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_d;

    // new bit enters at the top and walks toward bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sr_q <= '0;
        else if (sclk_rise) sr_q <= {sdat_s, sr_q[SR_W-1:1]};
    end

    // the first bit sent ends at bit 0, so each field sits bit-reversed
    generate
        for (genvar i = 0; i < T_W; i++) begin : g_t
            assign sr_cfg.t[T_W-1-i] = sr_q[i];
        end
        for (genvar i = 0; i < N_W; i++) begin : g_n
            assign sr_cfg.n[N_W-1-i] = sr_q[T_W+i];
        end
        for (genvar i = 0; i < M_W; i++) begin : g_m
            assign sr_cfg.m[M_W-1-i] = sr_q[T_W+N_W+i];
        end
    endgenerate
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pld_s,
    input  logic      sld_s,
    output ld_state_e state_q,
    output logic      ld_par,
    output logic      ld_ser
);
    ld_state_e state_nxt;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_PAR:  if (pld_s) state_nxt = ST_IDLE;
            ST_IDLE: begin
                if (!pld_s)     state_nxt = ST_PAR;
                else if (sld_s) state_nxt = ST_SER;
            end
            ST_SER: begin
                if (!pld_s)      state_nxt = ST_PAR;
                else if (!sld_s) state_nxt = ST_IDLE;
            end
            default:             state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    always_comb begin
        ld_par = 1'b0;
        ld_ser = 1'b0;
        unique case (state_q)
            ST_PAR:  ld_par = 1'b1;
            ST_SER:  ld_ser = 1'b1;
            ST_IDLE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/cfgport_latch.sv
module cfgport_latch
    import cfgport_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_par,
    input  logic           ld_ser,
    input  logic [M_W-1:0] pin_m,
    input  logic [N_W-1:0] pin_n,
    input  cfg_t           sr_cfg,
    output cfg_t           cfg_q
);
    logic [M_W-1:0] pin_m_d;
    logic [N_W-1:0] pin_n_d;

    // one more stage keeps the pins in step with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_m_d <= '0;
            pin_n_d <= '0;
        end else begin
            pin_m_d <= pin_m;
            pin_n_d <= pin_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (ld_par) begin
            cfg_q.t <= '0;
            cfg_q.n <= pin_n_d;
            cfg_q.m <= pin_m_d;
        end else if (ld_ser) begin
            cfg_q <= sr_cfg;
        end
    end
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_ld,
    input  logic           par_ld,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output logic [T_W-1:0] test_sel,
    output logic [N_W-1:0] post_div,
    output logic [M_W-1:0] fb_div,
    output logic           ser_out
);
    localparam int IN_W = 4 + N_W + M_W;
    localparam logic [IN_W-1:0] IN_RST = {3'b000, 1'b1, {(N_W+M_W){1'b0}}};

    logic [IN_W-1:0] in_s;
    logic            sclk_s, sdat_s, sld_s, pld_s;
    logic [N_W-1:0]  pin_n_s;
    logic [M_W-1:0]  pin_m_s;
    logic            sclk_rise;
    logic [SR_W-1:0] sr_q;
    cfg_t            sr_cfg;
    cfg_t            cfg_q;
    ld_state_e       state_q;
    logic            ld_par, ld_ser;

    cfgport_sync #(
        .W       (IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_dat, ser_ld, par_ld, par_n, par_m}),
        .q     (in_s)
    );

    assign {sclk_s, sdat_s, sld_s, pld_s, pin_n_s, pin_m_s} = in_s;

    cfgport_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .sdat_s    (sdat_s),
        .sclk_rise (sclk_rise),
        .sr_q      (sr_q),
        .sr_cfg    (sr_cfg)
    );

    cfgport_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .pld_s   (pld_s),
        .sld_s   (sld_s),
        .state_q (state_q),
        .ld_par  (ld_par),
        .ld_ser  (ld_ser)
    );

    cfgport_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_par (ld_par),
        .ld_ser (ld_ser),
        .pin_m  (pin_m_s),
        .pin_n  (pin_n_s),
        .sr_cfg (sr_cfg),
        .cfg_q  (cfg_q)
    );

    assign test_sel = cfg_q.t;
    assign post_div = cfg_q.n;
    assign fb_div   = cfg_q.m;
    assign ser_out  = sr_q[0];
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk
    import cfgport_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  ld_state_e      state_q,
    input  logic           sclk_rise,
    input  logic [SR_W-1:0] sr_q,
    input  logic [T_W-1:0] test_sel,
    input  logic [N_W-1:0] post_div,
    input  logic [M_W-1:0] fb_div
);
    // R1: reset clears the latched fields
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (test_sel == '0 && post_div == '0 && fb_div == '0));

    // R2: no serial clock edge, no movement
    a_r2_single_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(sr_q));

    // R4: serial state copies the register ends into the fields
    a_r4_ser_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SER) |=>
            (test_sel[T_W-1] == $past(sr_q[0]) && fb_div[0] == $past(sr_q[SR_W-1])));

    // R5 / R7: idle state holds every field
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=>
            ($stable(test_sel) && $stable(post_div) && $stable(fb_div)));

    // R6 / R9: parallel state forces the test field clear
    a_r6_test_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAR) |=> (test_sel == '0));

    // R8: exactly one load source is active at a time
    a_r8_one_state: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);
endmodule

bind cfgport_top cfgport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .sclk_rise (sclk_rise),
    .sr_q      (sr_q),
    .test_sel  (test_sel),
    .post_div  (post_div),
    .fb_div    (fb_div)
);

// File: tb/cfgport_top_tb_top.sv
`timescale 1ns/1ps
module cfgport_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, par_ld = 1'b1;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic [2:0] test_sel;
    logic [1:0] post_div;
    logic [8:0] fb_div;
    logic       ser_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0] t;
        logic [1:0] n;
        logic [8:0] m;
        bit         chk_so;
        logic       so;
        string      req;
    } exp_s;

    exp_s q[$];
    exp_s item;

    always #2.5 clk = ~clk;

    cfgport_top dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_ld(ser_ld), .par_ld(par_ld), .par_m(par_m), .par_n(par_n),
        .test_sel(test_sel), .post_div(post_div), .fb_div(fb_div), .ser_out(ser_out)
    );

    // monitor: pop one expected item and compare away from the edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item = q.pop_front();
            checks++;
            if (test_sel !== item.t || post_div !== item.n || fb_div !== item.m) begin
                errors++;
                $display("FAIL %s: got T=%b N=%b M=%h expected T=%b N=%b M=%h",
                         item.req, test_sel, post_div, fb_div, item.t, item.n, item.m);
            end
            if (item.chk_so && ser_out !== item.so) begin
                errors++;
                $display("FAIL %s: ser_out got %b expected %b", item.req, ser_out, item.so);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_cfg(input logic [2:0] t, input logic [1:0] n,
                              input logic [8:0] m, input bit chk_so,
                              input logic so, input string req);
        exp_s e;
        e.t = t; e.n = n; e.m = m; e.chk_so = chk_so; e.so = so; e.req = req;
        q.push_back(e);
        while (q.size() > 0) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(6);
        ser_clk = 1'b0;
        wait_clk(4);
    endtask

    task automatic send_frame(input logic [2:0] t, input logic [1:0] n, input logic [8:0] m);
        logic [13:0] f;
        f = {t, n, m};
        for (int i = 13; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic pulse_sld();
        ser_ld = 1'b1;
        wait_clk(6);
        ser_ld = 1'b0;
        wait_clk(6);
    endtask

    initial begin
        wait_clk(3);
        // R1: during reset
        expect_cfg(3'b000, 2'b00, 9'h000, 1'b1, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        wait_clk(8);
        expect_cfg(3'b000, 2'b00, 9'h000, 1'b1, 1'b0, "R1 after reset");

        // frame A: T=101 N=10 M=1A5
        send_frame(3'b101, 2'b10, 9'h1A5);
        wait_clk(6);
        // R5: no strobe yet, outputs untouched; R2: first bit at bottom
        expect_cfg(3'b000, 2'b00, 9'h000, 1'b1, 1'b1, "R5/R2 frame shifted, no load");
        pulse_sld();
        expect_cfg(3'b101, 2'b10, 9'h1A5, 1'b0, 1'b0, "R3 frame A loaded");

        // R2: each long clock pulse moves exactly one place
        send_bit(1'b0);
        wait_clk(4);
        expect_cfg(3'b101, 2'b10, 9'h1A5, 1'b1, 1'b0, "R2 one shift -> T1");
        send_bit(1'b0);
        wait_clk(4);
        expect_cfg(3'b101, 2'b10, 9'h1A5, 1'b1, 1'b1, "R2 one shift -> T0");

        // R4: strobe held high while frame B shifts in
        ser_ld = 1'b1;
        send_frame(3'b011, 2'b01, 9'h0F0);
        wait_clk(6);
        expect_cfg(3'b011, 2'b01, 9'h0F0, 1'b0, 1'b0, "R4 transparent during strobe");
        ser_ld = 1'b0;
        wait_clk(6);

        // R5: frame C shifts without a strobe
        send_frame(3'b110, 2'b00, 9'h10B);
        wait_clk(6);
        expect_cfg(3'b011, 2'b01, 9'h0F0, 1'b0, 1'b0, "R5 held after strobe fall");

        // R6: parallel transparency
        par_m = 9'h123; par_n = 2'b11; par_ld = 1'b0;
        wait_clk(8);
        expect_cfg(3'b000, 2'b11, 9'h123, 1'b0, 1'b0, "R6 pins followed");
        par_m = 9'h0AA; par_n = 2'b01;
        wait_clk(8);
        expect_cfg(3'b000, 2'b01, 9'h0AA, 1'b0, 1'b0, "R6 pins followed again");
        // R7: capture on rise
        par_ld = 1'b1;
        wait_clk(8);
        par_m = 9'h1FF; par_n = 2'b00;
        wait_clk(8);
        expect_cfg(3'b000, 2'b01, 9'h0AA, 1'b0, 1'b0, "R7 captured on rise");

        // R8: serial strobe ignored while parallel strobe low
        par_m = 9'h055; par_n = 2'b10; par_ld = 1'b0;
        wait_clk(4);
        ser_ld = 1'b1;
        wait_clk(10);
        expect_cfg(3'b000, 2'b10, 9'h055, 1'b0, 1'b0, "R8 parallel wins");
        ser_ld = 1'b0;
        wait_clk(6);
        par_ld = 1'b1;
        wait_clk(8);
        expect_cfg(3'b000, 2'b10, 9'h055, 1'b0, 1'b0, "R8 nothing leaked from shift reg");
        pulse_sld();
        expect_cfg(3'b110, 2'b00, 9'h10B, 1'b0, 1'b0, "R8 serial load works again");

        // R9: parallel load clears a nonzero test field
        par_m = 9'h0C3; par_n = 2'b11; par_ld = 1'b0;
        wait_clk(8);
        expect_cfg(3'b000, 2'b11, 9'h0C3, 1'b0, 1'b0, "R9 T forced 000");
        par_ld = 1'b1;
        wait_clk(8);
        expect_cfg(3'b000, 2'b11, 9'h0C3, 1'b0, 1'b0, "R9 T stays 000");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule